// File: doc/BRIEF.md
# Serial Priority Interrupt Chain

The block chains a set of interrupting sources in series so they can share one request line to a processor. Each source has a stage. A stage keeps a pending bit that the source sets with a one-cycle pulse. A stage also takes a priority token from the stage before it and passes the token on to the stage after it. The shared request output is high while any stage holds a pending bit.

When the processor answers with its acknowledge level, that level enters the first stage as the token. The token moves down the chain until it reaches the first stage that is pending. That stage keeps the token, which stops every later stage. It also places its own fixed vector on a shared bus, so the processor can jump to the matching handler.

When acknowledge falls, the stage that held the token drops its pending bit. In this way each request is served once. A request that arrives while acknowledge is high is stored, but it cannot take the token from the stage already chosen in that acknowledge.

Top module: `prio_ripple_irq`

## Requirements
- R1: Priority follows chain position. When acknowledge is high, the pending stage with the lowest index (stage 0 is the first in the chain) takes the token.
- R2: A one-cycle pulse on bit i of `src_req` sets pending bit i at the next rising clock edge. `irq_out` is then high while at least one pending bit is set, and low when none is set.
- R3: While `ack_in` is low, `vec_bus` is all zeros and `chain_tail` is 0, whatever is pending.
- R4: When `ack_in` is high and no stage is pending, the token passes through every stage: `chain_tail` is 1 and `vec_bus` is all zeros.
- R5: When `ack_in` is high and some stage is pending, exactly one stage is chosen and `chain_tail` is 0. For the chosen stage i, `vec_bus` equals VEC_BASE + i*VEC_STEP. The defaults give 8'h40 + 8*i.
- R6: At the clock edge that samples `ack_in` falling, the chosen stage clears its pending bit. This holds however many cycles acknowledge stayed high. Pending bits of other stages are not changed.
- R7: A request that arrives while `ack_in` is high is stored, but it does not change the chosen stage or `vec_bus` until acknowledge falls. It is served in a later acknowledge.
- R8: Reset clears every pending bit, so `irq_out` is low after reset.
- R9: A new request from the chosen stage, applied at the same edge that clears that stage, takes precedence. The stage stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | One-cycle set pulse per source; bit 0 has the highest priority |
| ack_in | input | 1 | Processor acknowledge level; feeds the token into stage 0 |
| irq_out | output | 1 | Shared request line; wired-OR of all pending bits |
| vec_bus | output | VEC_W | Vector of the chosen stage; zero when no stage is chosen |
| chain_tail | output | 1 | Token leaving the last stage; high when acknowledge found no pending stage |

## Verification
A table of request patterns drives the chain:
- no request at all;
- each stage alone;
- pairs of stages;
- all stages at once.

Each pattern is drained by repeated acknowledges, and the bench checks that the vectors appear in lowest-index-first order. This separates positional priority from any other ordering, and it also shows that each source is served exactly once.

Directed cases then check four further behaviours:
- a request that arrives in the middle of an acknowledge;
- a new request that meets its own clear at the falling edge;
- an acknowledge held for several cycles;
- a reset that arrives while requests are pending.

These cases separate the frozen choice of stage during acknowledge from a fully live chain, and they test that the clear happens on the falling edge.

// File: rtl/prio_ripple_pkg.sv
package prio_ripple_pkg;

   // Vector of stage idx, computed as base plus idx steps.
   function automatic logic [31:0] stage_vector(input int unsigned base,
                                                input int unsigned step,
                                                input int unsigned idx);
      return 32'(base + idx * step);
   endfunction

endpackage

// File: rtl/prio_ack_track.sv
module prio_ack_track (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_in,
   output logic ack_prev,
   output logic ack_first,
   output logic ack_fall
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_prev <= 1'b0;
      else        ack_prev <= ack_in;
   end

   // First cycle of an acknowledge: the choice of stage is snapshotted here.
   assign ack_first = ack_in & ~ack_prev;
   // Acknowledge has dropped: the chosen stage clears at this edge.
   assign ack_fall  = ack_prev & ~ack_in;

endmodule

// File: rtl/prio_stage.sv
module prio_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic req_set,
   input  logic ack_lvl,
   input  logic ack_prev,
   input  logic ack_first,
   input  logic ack_fall,
   input  logic tok_in,
   output logic tok_out,
   output logic vec_en,
   output logic pend
);

   logic pend_q;
   logic snap_q;
   logic gnt_q;
   logic view;

   // Once acknowledge has lasted a cycle, the chain looks at the snapshot.
   assign view    = ack_prev ? snap_q : pend_q;
   assign vec_en  = tok_in & view;
   assign tok_out = tok_in & ~view;
   assign pend    = pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         snap_q <= 1'b0;
         gnt_q  <= 1'b0;
      end else begin
         // A new set wins over the clear in the same cycle.
         pend_q <= req_set | (pend_q & ~(ack_fall & gnt_q));
         if (ack_first) snap_q <= pend_q;
         gnt_q  <= ack_lvl ? vec_en : 1'b0;
      end
   end

   AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && gnt_q && !req_set) |=> !pend_q); // R6

   AST_GRANT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_prev && ack_lvl) |-> $stable(vec_en)); // R7

   AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      req_set |=> pend_q); // R9

endmodule

// File: rtl/prio_vec_merge.sv
module prio_vec_merge #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 8'h40,
   parameter int unsigned VEC_STEP = 8'h08
) (
   input  logic [NUM_SRC-1:0] sel,
   output logic [VEC_W-1:0]   bus
);

   import prio_ripple_pkg::*;

   // Open-drain style bus: enabled stages OR their vectors onto it.
   always_comb begin
      bus = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel[i]) bus = bus | VEC_W'(stage_vector(VEC_BASE, VEC_STEP, i));
      end
   end

endmodule

// File: rtl/prio_ripple_irq.sv
module prio_ripple_irq #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 8'h40,
   parameter int unsigned VEC_STEP = 8'h08
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               ack_in,
   output logic               irq_out,
   output logic [VEC_W-1:0]   vec_bus,
   output logic               chain_tail
);

   localparam int unsigned LastVec = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

   if (NUM_SRC < 2) begin : g_bad_count
      $error("prio_ripple_irq: NUM_SRC must be at least 2");
   end
   if (VEC_W < 1 || VEC_W > 31) begin : g_bad_width
      $error("prio_ripple_irq: VEC_W out of range");
   end
   if (LastVec >= (32'd1 << VEC_W) || VEC_STEP == 0) begin : g_bad_vec
      $error("prio_ripple_irq: vectors do not fit or are not distinct");
   end

   logic               ack_prev;
   logic               ack_first;
   logic               ack_fall;
   logic [NUM_SRC:0]   tok;
   logic [NUM_SRC-1:0] sel;
   logic [NUM_SRC-1:0] pend;

   prio_ack_track u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .ack_in    (ack_in),
      .ack_prev  (ack_prev),
      .ack_first (ack_first),
      .ack_fall  (ack_fall)
   );

   assign tok[0] = ack_in;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_stage
      prio_stage u_stage (
         .clk       (clk),
         .rst_n     (rst_n),
         .req_set   (src_req[i]),
         .ack_lvl   (ack_in),
         .ack_prev  (ack_prev),
         .ack_first (ack_first),
         .ack_fall  (ack_fall),
         .tok_in    (tok[i]),
         .tok_out   (tok[i+1]),
         .vec_en    (sel[i]),
         .pend      (pend[i])
      );
   end

   prio_vec_merge #(
      .NUM_SRC  (NUM_SRC),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_merge (
      .sel (sel),
      .bus (vec_bus)
   );

   assign irq_out    = |pend;
   assign chain_tail = tok[NUM_SRC];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel)); // R5

   AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_in |-> (vec_bus == '0 && !chain_tail)); // R3

   AST_EMPTY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_in && sel == '0) |-> chain_tail); // R4

   AST_REQ_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (src_req != '0) |=> irq_out); // R2

endmodule

// File: tb/prio_ripple_irq_bench.sv
module prio_ripple_irq_bench;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] src_req = '0;
   logic         ack_in = 1'b0;
   logic         irq_out;
   logic [7:0]   vec_bus;
   logic         chain_tail;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // Row layout: {request pattern[3:0], first expected vector[7:0]}
   localparam logic [11:0] ROWS [10] = '{
      {4'b0000, 8'h00}, {4'b0001, 8'h40}, {4'b0010, 8'h48}, {4'b0100, 8'h50},
      {4'b1000, 8'h58}, {4'b0110, 8'h48}, {4'b1100, 8'h50}, {4'b1111, 8'h40},
      {4'b1010, 8'h48}, {4'b0101, 8'h40}
   };

   prio_ripple_irq u_prio_ripple_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_req    (src_req),
      .ack_in     (ack_in),
      .irq_out    (irq_out),
      .vec_bus    (vec_bus),
      .chain_tail (chain_tail)
   );

   always #4 clk = ~clk;

   function automatic logic [7:0] vec_of(input int idx);
      return 8'(8'h40 + 8 * idx);
   endfunction

   function automatic int lowest(input logic [N-1:0] m);
      for (int i = 0; i < N; i++) if (m[i]) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_req(input logic [N-1:0] m);
      @(negedge clk); src_req = m;
      @(negedge clk); src_req = '0;
   endtask

   // One acknowledge of one cycle; checks the vector the chain presents.
   task automatic ack_pulse(input logic [7:0] exp_vec, input string req);
      @(negedge clk); ack_in = 1'b1;
      #1;
      check(vec_bus == exp_vec, req, vec_bus, exp_vec);
      @(negedge clk); ack_in = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [N-1:0] rem;
      repeat (3) @(negedge clk);
      #1;
      check(irq_out == 1'b0, "R8 irq in reset", irq_out, 0);
      check(vec_bus == 8'h00, "R3 bus in reset", vec_bus, 0);
      @(negedge clk); rst_n = 1'b1;

      // Table walk: R1 order, R2 irq, R4/R5 first grant, R6 single service
      for (int r = 0; r < 10; r++) begin
         logic [N-1:0] pat;
         logic [7:0]   fv;
         pat = ROWS[r][11:8];
         fv  = ROWS[r][7:0];
         pulse_req(pat);
         #1;
         check(irq_out == (pat != 0), "R2 irq after set", irq_out, 32'(pat != 0));
         @(negedge clk); ack_in = 1'b1;
         #1;
         check(vec_bus == fv, "R5 first vector", vec_bus, fv);
         check(chain_tail == (pat == 0), "R4 chain tail", chain_tail, 32'(pat == 0));
         @(negedge clk); ack_in = 1'b0;
         rem = pat;
         if (rem != 0) rem[lowest(rem)] = 1'b0;
         while (rem != 0) begin
            ack_pulse(vec_of(lowest(rem)), "R1 drain order");
            rem[lowest(rem)] = 1'b0;
         end
         @(negedge clk); #1;
         check(irq_out == 1'b0, "R6 drained once", irq_out, 0);
      end

      // R3: pending but no acknowledge
      pulse_req(4'b1000);
      #1;
      check(vec_bus == 8'h00 && chain_tail == 1'b0, "R3 idle bus",
            {vec_bus, 7'b0, chain_tail}, 0);
      ack_pulse(8'h58, "R3 then served");

      // R7: higher-priority request during an acknowledge cannot preempt
      pulse_req(4'b0100);
      ack_in = 1'b1;
      #1;
      check(vec_bus == 8'h50, "R7 initial grant", vec_bus, 8'h50);
      @(negedge clk); src_req = 4'b0001;
      @(negedge clk); src_req = '0;
      #1;
      check(vec_bus == 8'h50, "R7 no preempt", vec_bus, 8'h50);
      check(irq_out == 1'b1, "R7 latched", irq_out, 1);
      @(negedge clk); ack_in = 1'b0;
      ack_pulse(8'h40, "R7 later service");
      @(negedge clk); #1;
      check(irq_out == 1'b0, "R7 all served", irq_out, 0);

      // R9: new request meets its own clear
      pulse_req(4'b0010);
      ack_in = 1'b1;
      @(negedge clk); ack_in = 1'b0; src_req = 4'b0010;
      @(negedge clk); src_req = '0;
      #1;
      check(irq_out == 1'b1, "R9 set wins", irq_out, 1);
      ack_pulse(8'h48, "R9 served again");
      @(negedge clk); #1;
      check(irq_out == 1'b0, "R9 cleared", irq_out, 0);

      // R6: long acknowledge still serves one stage once
      pulse_req(4'b0011);
      ack_in = 1'b1;
      for (int k = 0; k < 5; k++) begin
         #1;
         check(vec_bus == 8'h40, "R6 long ack stable", vec_bus, 8'h40);
         @(negedge clk);
      end
      ack_in = 1'b0;
      ack_pulse(8'h48, "R6 next stage");
      @(negedge clk); #1;
      check(irq_out == 1'b0, "R6 long ack done", irq_out, 0);

      // R8: reset with pending requests
      pulse_req(4'b1111);
      rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #1;
      check(irq_out == 1'b0, "R8 reset clears", irq_out, 0);
      @(negedge clk); ack_in = 1'b1;
      #1;
      check(vec_bus == 8'h00 && chain_tail == 1'b1, "R8 nothing pending",
            {vec_bus, 7'b0, chain_tail}, 1);
      @(negedge clk); ack_in = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule